// File: doc/BRIEF.md
# Serial Controller Flag and Register Unit

This unit holds the programmable state of an 8/9-bit asynchronous serial controller and runs the status flags around a separate shifter. A byte-wide CPU port reaches five registers: rate select, two control registers, status and data. A deserializer reports each finished character with a strobe, the byte and its noise and framing indications, and it reports idle line periods with a second strobe. A serializer receives a one-cycle load pulse with the byte to send, and it reports the end of each frame with a done strobe.

The unit works out the bit period and the full frame time from the rate and control registers, so that both shifters can be timed from it. Receive flags stay set until software reads status and then data. The second read clears only the flags that the first read saw. A character that arrives between the two reads cancels the pending clear. The transmit side holds one byte. It marks the data register empty, and later the frame complete, as each frame is started and then finished. One interrupt request line combines the flags with their enables.

Top module: `sci_flag_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the rate register and both control registers become 0x00 and status becomes 0xC0. Received data, any pending capture and any pending transmit byte are dropped, and tx_load is 0.
- R2: Register addresses are 0 rate, 1 control-1, 2 control-2, 3 status and 4 received data. Rate and control registers read back the value last written. Any other address reads 0x00.
- R3: bit_cycles = P*16*2^S, where S is rate bits [2:0] and P comes from rate bits [5:4] (0:1, 1:3, 2:4, 3:13). The frame length is 11 bit times when control-1 bit 4 is set and 10 when it is clear. frame_cycles = frame length * bit_cycles.
- R4: Status bits are TDRE=7, TC=6, RDRF=5, IDLE=4, OR=3, NF=2, FE=1, and bit 0 reads 0. When control-2 bit 2 (receive enable) is set, a character strobe stores the byte and sets RDRF, and it also sets NF or FE when the matching input is high. An idle strobe sets IDLE. When receive enable is clear, both strobes are ignored.
- R5: A status read captures which of RDRF, IDLE, OR, NF and FE are set. The next data read clears exactly those flags. A data read with no capture pending clears nothing.
- R6: A character that arrives while RDRF is set also sets OR and replaces the stored byte.
- R7: An accepted character cancels a pending capture. When a data read and a character fall in the same cycle, the read returns the old byte and no flag is cleared.
- R8: Writes to the status address change nothing.
- R9: A data write is ignored while TDRE is 0. When it is accepted with control-2 bit 3 (transmit enable) set, tx_load pulses for one cycle in the next cycle with the byte on tx_byte, and TDRE and TC read 0.
- R10: A data write accepted while transmit enable is clear is held (a later write replaces it), and TDRE stays 1. The held byte is loaded once transmit enable is set.
- R11: tx_done during a frame sets TDRE and TC.
- R12: Control-2 bits are TIE=7, TCIE=6, RIE=5, ILIE=4. irq = (TIE&TDRE)|(TCIE&TC)|(RIE&(RDRF|OR))|(ILIE&IDLE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 3 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe (side effects for status and data) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| rx_valid | input | 1 | Character received strobe |
| rx_byte | input | 8 | Received byte |
| rx_noise | input | 1 | Noise seen on this character |
| rx_ferr | input | 1 | Framing error on this character |
| rx_idle | input | 1 | Idle line detected strobe |
| tx_load | output | 1 | Start-frame pulse to the serializer |
| tx_byte | output | 8 | Byte for the frame being started |
| tx_done | input | 1 | Serializer finished its frame |
| bit_cycles | output | 15 | Clock cycles per bit |
| frame_cycles | output | 19 | Clock cycles per frame |
| irq | output | 1 | Combined interrupt request |

## Verification
Two collisions get the most attention. In the first, a character arrives in the same cycle as the data read that would complete a clear. The bench drives both strobes together and expects the old byte on the read, the new flags kept, and OR raised. In the second, the enable for a held transmit byte rises, and the load must follow on the next edge. A behavioural model in the bench advances on every edge and compares read data, irq, the load pulse, its byte and the timing outputs each cycle. Directed checks pin the hand-computed values.

// File: rtl/sci_pkg.sv
// Shared register addresses and bit positions for the serial flag unit.
// Assumes a byte-wide register port with 3 address bits.
package sci_pkg;
    typedef enum logic [2:0] {
        A_RATE = 3'd0,
        A_CTL1 = 3'd1,
        A_CTL2 = 3'd2,
        A_STAT = 3'd3,
        A_DATA = 3'd4
    } sci_addr_e;

    // status bit positions
    localparam int ST_TDRE = 7;
    localparam int ST_TC   = 6;
    // control-2 bit positions
    localparam int C2_TIE  = 7;
    localparam int C2_TCIE = 6;
    localparam int C2_RIE  = 5;
    localparam int C2_ILIE = 4;
    localparam int C2_TE   = 3;
    localparam int C2_RE   = 2;
    // control-1 long-frame bit
    localparam int C1_LONG = 4;
    // receive flag vector order: {rdrf, idle, ovr, noise, ferr}
    localparam int RF_RDRF = 4;
    localparam int RF_IDLE = 3;
    localparam int RF_OVR  = 2;
    localparam int RF_W    = 5;
endpackage

// File: rtl/sci_cfg_regs.sv
// Rate and control registers plus bit and frame timing derivation.
// Assumes the prescale field sits at rate bits [5:4] and the shift field at the low bits.
module sci_cfg_regs
    import sci_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int RATE_W = 3,
    localparam int BIT_W   = $clog2(13*OVS+1) + (1 << RATE_W) - 1,
    localparam int FRAME_W = BIT_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_rate,
    input  logic               wr_ctl1,
    input  logic               wr_ctl2,
    input  logic [7:0]         wdata,
    output logic [7:0]         rate_q,
    output logic [7:0]         ctl1_q,
    output logic [7:0]         ctl2_q,
    output logic [BIT_W-1:0]   bit_cycles,
    output logic [FRAME_W-1:0] frame_cycles
);
    logic [BIT_W-1:0] base;
    logic [3:0]       frame_len;

    // register writes, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            ctl1_q <= '0;
            ctl2_q <= '0;
        end else begin
            if (wr_rate) rate_q <= wdata;
            if (wr_ctl1) ctl1_q <= wdata;
            if (wr_ctl2) ctl2_q <= wdata;
        end
    end

    // prescaler selection times oversampling
    always_comb begin
        case (rate_q[5:4])
            2'd0:    base = BIT_W'(OVS);
            2'd1:    base = BIT_W'(3*OVS);
            2'd2:    base = BIT_W'(4*OVS);
            default: base = BIT_W'(13*OVS);
        endcase
    end

    // bit period, frame length and frame time
    always_comb begin
        bit_cycles   = base << rate_q[RATE_W-1:0];
        frame_len    = ctl1_q[C1_LONG] ? 4'd11 : 4'd10;
        frame_cycles = FRAME_W'(bit_cycles) * FRAME_W'(frame_len);
    end
endmodule

// File: rtl/sci_rx_flags.sv
// Receive flags, received byte and the two-step (status then data) clear.
// Assumes strobes are single-cycle and already qualified by the deserializer.
module sci_rx_flags
    import sci_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            rx_noise,
    input  logic            rx_ferr,
    input  logic            rx_idle,
    input  logic            rd_stat,
    input  logic            rd_data,
    output logic [RF_W-1:0] flags_q,
    output logic [7:0]      rx_data_q
);
    logic [RF_W-1:0] cap_q;
    logic [RF_W-1:0] clr;
    logic [RF_W-1:0] flags_d;
    logic            accept;
    logic            idle_set;

    assign accept   = rx_valid & rx_en;
    assign idle_set = rx_idle & rx_en;

    // clear mask applies only when no character arrives in the same cycle
    assign clr = (rd_data && !accept) ? cap_q : '0;

    // next flag state: clear first, then sets win
    always_comb begin
        flags_d = flags_q & ~clr;
        if (accept) begin
            flags_d[RF_RDRF] = 1'b1;
            flags_d[RF_OVR]  = flags_q[RF_OVR] | flags_q[RF_RDRF];
            flags_d[1]       = flags_q[1] | rx_noise;
            flags_d[0]       = flags_q[0] | rx_ferr;
        end
        if (idle_set) flags_d[RF_IDLE] = 1'b1;
    end

    // flag, capture and byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            cap_q     <= '0;
            rx_data_q <= '0;
        end else begin
            flags_q <= flags_d;
            if (accept)       cap_q <= '0;
            else if (rd_stat) cap_q <= flags_q;
            else if (rd_data) cap_q <= '0;
            if (accept) rx_data_q <= rx_byte;
        end
    end

    p_rdrf_on_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> flags_q[RF_RDRF]);
    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && flags_q[RF_RDRF]) |=> flags_q[RF_OVR]);
    p_no_blind_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && cap_q == '0 && !accept && !idle_set) |=> flags_q == $past(flags_q));
    p_cancel_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cap_q == '0);
endmodule

// File: rtl/sci_tx_seq.sv
// One-byte transmit holding stage with empty/complete sequencing.
// Assumes tx_done arrives once per loaded frame.
module sci_tx_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       wr_data,
    input  logic [7:0] wdata,
    input  logic       tx_done,
    output logic       tdre_q,
    output logic       tc_q,
    output logic       tx_load,
    output logic [7:0] tx_byte
);
    logic       busy_q;
    logic       pend_q;
    logic [7:0] hold_q;
    logic       accept;
    logic       start;

    assign accept = wr_data & tdre_q;
    assign start  = tx_en & ~busy_q & (pend_q | accept);

    // frame start, holding and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdre_q  <= 1'b1;
            tc_q    <= 1'b1;
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            hold_q  <= '0;
            tx_load <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_load <= start;
            if (start) begin
                tx_byte <= accept ? wdata : hold_q;
                busy_q  <= 1'b1;
                pend_q  <= 1'b0;
                tdre_q  <= 1'b0;
                tc_q    <= 1'b0;
            end else begin
                if (accept) begin
                    pend_q <= 1'b1;
                    hold_q <= wdata;
                end
                if (tx_done && busy_q) begin
                    tdre_q <= 1'b1;
                    tc_q   <= 1'b1;
                    busy_q <= 1'b0;
                end
            end
        end
    end

    p_load_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
    p_empty_low_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (!tdre_q && !tc_q));
    p_done_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && busy_q) |=> (tdre_q && tc_q));
endmodule

// File: rtl/sci_flag_unit.sv
// Top: register decode, read mux and combined interrupt request.
// Assumes cpu_rd and cpu_wr are single-cycle strobes, one access per cycle.
module sci_flag_unit
    import sci_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int RATE_W = 3,
    localparam int BIT_W   = $clog2(13*OVS+1) + (1 << RATE_W) - 1,
    localparam int FRAME_W = BIT_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cpu_addr,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               rx_noise,
    input  logic               rx_ferr,
    input  logic               rx_idle,
    output logic               tx_load,
    output logic [7:0]         tx_byte,
    input  logic               tx_done,
    output logic [BIT_W-1:0]   bit_cycles,
    output logic [FRAME_W-1:0] frame_cycles,
    output logic               irq
);
    logic [7:0]      rate_q, ctl1_q, ctl2_q, rx_data_q, status;
    logic [RF_W-1:0] rx_flags;
    logic            tdre, tc;

    sci_cfg_regs #(.OVS(OVS), .RATE_W(RATE_W)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_rate(cpu_wr && cpu_addr == A_RATE),
        .wr_ctl1(cpu_wr && cpu_addr == A_CTL1),
        .wr_ctl2(cpu_wr && cpu_addr == A_CTL2),
        .wdata(cpu_wdata), .rate_q(rate_q), .ctl1_q(ctl1_q), .ctl2_q(ctl2_q),
        .bit_cycles(bit_cycles), .frame_cycles(frame_cycles)
    );

    sci_rx_flags rx_i (
        .clk(clk), .rst_n(rst_n), .rx_en(ctl2_q[C2_RE]),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_noise(rx_noise),
        .rx_ferr(rx_ferr), .rx_idle(rx_idle),
        .rd_stat(cpu_rd && cpu_addr == A_STAT),
        .rd_data(cpu_rd && cpu_addr == A_DATA),
        .flags_q(rx_flags), .rx_data_q(rx_data_q)
    );

    sci_tx_seq tx_i (
        .clk(clk), .rst_n(rst_n), .tx_en(ctl2_q[C2_TE]),
        .wr_data(cpu_wr && cpu_addr == A_DATA), .wdata(cpu_wdata),
        .tx_done(tx_done), .tdre_q(tdre), .tc_q(tc),
        .tx_load(tx_load), .tx_byte(tx_byte)
    );

    assign status = {tdre, tc, rx_flags, 1'b0};

    // read data selection
    always_comb begin
        case (cpu_addr)
            A_RATE:  cpu_rdata = rate_q;
            A_CTL1:  cpu_rdata = ctl1_q;
            A_CTL2:  cpu_rdata = ctl2_q;
            A_STAT:  cpu_rdata = status;
            A_DATA:  cpu_rdata = rx_data_q;
            default: cpu_rdata = '0;
        endcase
    end

    // combined interrupt request
    assign irq = (ctl2_q[C2_TIE]  & tdre)
               | (ctl2_q[C2_TCIE] & tc)
               | (ctl2_q[C2_RIE]  & (rx_flags[RF_RDRF] | rx_flags[RF_OVR]))
               | (ctl2_q[C2_ILIE] & rx_flags[RF_IDLE]);

    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl2_q[7:4] == 4'h0) |-> !irq);
endmodule

// File: tb/sci_flag_unit_tb.sv
`timescale 1ns/1ps
module sci_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        rx_valid = 1'b0, rx_noise = 1'b0, rx_ferr = 1'b0, rx_idle = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_load, tx_done = 1'b0, irq;
    logic [7:0]  tx_byte;
    logic [14:0] bit_cycles;
    logic [18:0] frame_cycles;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    // behavioural model state
    logic [7:0] m_rate, m_c1, m_c2, m_rxd, m_hold, m_tbyte;
    logic [4:0] m_fl, m_cap;
    logic       m_tdre, m_tc, m_busy, m_pend, m_load;

    always #4 clk = ~clk;

    sci_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_noise(rx_noise),
        .rx_ferr(rx_ferr), .rx_idle(rx_idle), .tx_load(tx_load),
        .tx_byte(tx_byte), .tx_done(tx_done), .bit_cycles(bit_cycles),
        .frame_cycles(frame_cycles), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model advances on every edge from the inputs driven before it
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_rate = 0; m_c1 = 0; m_c2 = 0; m_rxd = 0; m_hold = 0; m_tbyte = 0;
            m_fl = 0; m_cap = 0; m_tdre = 1; m_tc = 1; m_busy = 0; m_pend = 0; m_load = 0;
        end else begin
            logic te, re, acc, tacc, go;
            logic [4:0] clr, nf;
            te = m_c2[3]; re = m_c2[2];
            acc = rx_valid && re;
            clr = (cpu_rd && cpu_addr == 4 && !acc) ? m_cap : 5'd0;
            nf = m_fl & ~clr;
            if (acc) begin
                nf[2] = m_fl[2] | m_fl[4];
                nf[4] = 1; nf[1] = m_fl[1] | rx_noise; nf[0] = m_fl[0] | rx_ferr;
                m_rxd = rx_byte;
            end
            if (rx_idle && re) nf[3] = 1;
            if (acc) m_cap = 0;
            else if (cpu_rd && cpu_addr == 3) m_cap = m_fl;
            else if (cpu_rd && cpu_addr == 4) m_cap = 0;
            m_fl = nf;
            tacc = cpu_wr && cpu_addr == 4 && m_tdre;
            go = te && !m_busy && (m_pend || tacc);
            m_load = go;
            if (go) begin
                m_tbyte = tacc ? cpu_wdata : m_hold;
                m_busy = 1; m_pend = 0; m_tdre = 0; m_tc = 0;
            end else begin
                if (tacc) begin m_pend = 1; m_hold = cpu_wdata; end
                if (tx_done && m_busy) begin m_tdre = 1; m_tc = 1; m_busy = 0; end
            end
            if (cpu_wr && cpu_addr == 0) m_rate = cpu_wdata;
            if (cpu_wr && cpu_addr == 1) m_c1 = cpu_wdata;
            if (cpu_wr && cpu_addr == 2) m_c2 = cpu_wdata;
        end
    end

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_rate;
            3'd1: return m_c1;
            3'd2: return m_c2;
            3'd3: return {m_tdre, m_tc, m_fl, 1'b0};
            3'd4: return m_rxd;
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison, 2 ns after the falling edge
    always begin
        @(negedge clk);
        #2;
        if (started) begin
            int pre, bitc, frm;
            case (m_rate[5:4]) 2'd0: pre = 1; 2'd1: pre = 3; 2'd2: pre = 4; default: pre = 13; endcase
            bitc = pre * 16 * (1 << m_rate[2:0]);
            frm  = bitc * (m_c1[4] ? 11 : 10);
            check("R2 model rdata", cpu_rdata, exp_rdata(cpu_addr));
            check("R12 model irq", irq, (m_c2[7] & m_tdre) | (m_c2[6] & m_tc)
                  | (m_c2[5] & (m_fl[4] | m_fl[2])) | (m_c2[4] & m_fl[3]));
            check("R9 model load", tx_load, m_load);
            check("R9 model byte", tx_byte, m_tbyte);
            check("R3 model bit", bit_cycles, bitc);
            check("R3 model frame", frame_cycles, frm);
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wr = 1; cpu_wdata = d; tick(); cpu_wr = 0;
    endtask
    task automatic rd(input logic [2:0] a);
        cpu_addr = a; cpu_rd = 1; tick(); cpu_rd = 0;
    endtask
    task automatic rxc(input logic [7:0] b, input logic n, input logic f);
        rx_valid = 1; rx_byte = b; rx_noise = n; rx_ferr = f; tick();
        rx_valid = 0; rx_noise = 0; rx_ferr = 0;
    endtask
    task automatic peek(input logic [2:0] a, input string tag, input logic [7:0] e);
        cpu_addr = a; #1; check(tag, cpu_rdata, e);
    endtask
    task automatic pulse_idle();
        rx_idle = 1; tick(); rx_idle = 0;
    endtask
    task automatic pulse_done();
        tx_done = 1; tick(); tx_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        peek(3, "R1 status after reset", 8'hC0);
        peek(2, "R1 ctl2 after reset", 8'h00);
        check("R1 irq after reset", irq, 0);
        check("R1 load after reset", tx_load, 0);
        peek(5, "R2 unused address", 8'h00);
        // R3 timing
        check("R3 reset bit", bit_cycles, 16);
        check("R3 reset frame", frame_cycles, 160);
        wr(1, 8'h10);
        check("R3 long frame", frame_cycles, 176);
        wr(0, 8'h13);
        peek(0, "R2 rate readback", 8'h13);
        check("R3 bit 3x8", bit_cycles, 384);
        check("R3 frame 3x8", frame_cycles, 4224);
        wr(0, 8'h37);
        check("R3 bit max", bit_cycles, 26624);
        check("R3 frame max", frame_cycles, 292864);
        wr(1, 8'h00);
        check("R3 frame max short", frame_cycles, 266240);
        wr(0, 8'h00);
        // R4 receive
        rxc(8'h99, 0, 0);
        peek(3, "R4 char ignored while disabled", 8'hC0);
        pulse_idle();
        peek(3, "R4 idle ignored while disabled", 8'hC0);
        wr(2, 8'h04);
        rxc(8'h5A, 0, 0);
        peek(3, "R4 rdrf set", 8'hE0);
        peek(4, "R4 byte stored", 8'h5A);
        // R6 overrun
        rxc(8'h77, 0, 1);
        peek(3, "R6 overrun and framing", 8'hEA);
        peek(4, "R6 byte replaced", 8'h77);
        // R5 two-step clear
        rd(3); rd(4);
        peek(3, "R5 captured flags cleared", 8'hC0);
        rxc(8'h11, 0, 0);
        rd(4);
        peek(3, "R5 data read alone clears nothing", 8'hE0);
        rd(3); rd(4);
        // R7 cancel
        rxc(8'h22, 0, 0);
        rd(3);
        rxc(8'h33, 1, 0);
        rd(4);
        peek(3, "R7 capture cancelled", 8'hEC);
        rd(3);
        cpu_addr = 4; cpu_rd = 1; rx_valid = 1; rx_byte = 8'h44;
        #1; check("R7 same-cycle read returns old byte", cpu_rdata, 8'h33);
        tick(); cpu_rd = 0; rx_valid = 0;
        peek(3, "R7 same-cycle flags kept", 8'hEC);
        peek(4, "R7 new byte", 8'h44);
        rd(3); rd(4);
        peek(3, "R5 cleared again", 8'hC0);
        pulse_idle();
        peek(3, "R4 idle set", 8'hD0);
        rd(3); rd(4);
        // R8 status write
        rxc(8'h55, 0, 0);
        wr(3, 8'h00);
        peek(3, "R8 status write ignored", 8'hE0);
        rd(3); rd(4);
        // R12 irq
        wr(2, 8'h84);
        check("R12 tie with tdre", irq, 1);
        wr(2, 8'h24);
        check("R12 rie idle", irq, 0);
        rxc(8'h66, 0, 0);
        check("R12 rie rdrf", irq, 1);
        rd(3); rd(4);
        check("R12 rie cleared", irq, 0);
        wr(2, 8'h14);
        pulse_idle();
        check("R12 ilie idle", irq, 1);
        rd(3); rd(4);
        // R9 transmit
        wr(2, 8'h08);
        wr(4, 8'hA5);
        check("R9 load pulse", tx_load, 1);
        check("R9 load byte", tx_byte, 8'hA5);
        peek(3, "R9 empty and complete low", 8'h00);
        tick();
        check("R9 load one cycle", tx_load, 0);
        wr(4, 8'h3C);
        pulse_done();
        peek(3, "R11 done sets flags", 8'hC0);
        tick();
        check("R9 write while full ignored", tx_load, 0);
        wr(2, 8'h48);
        check("R12 tcie with tc", irq, 1);
        // R10 held byte
        wr(2, 8'h00);
        wr(4, 8'h81);
        check("R10 no load while disabled", tx_load, 0);
        peek(3, "R10 tdre stays set", 8'hC0);
        wr(4, 8'h82);
        wr(2, 8'h08);
        tick();
        check("R10 held byte loaded", tx_load, 1);
        check("R10 latest byte", tx_byte, 8'h82);
        pulse_done();
        peek(3, "R11 second frame done", 8'hC0);
        repeat (3) tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule